// File: doc/BRIEF.md
# Interrupt Mask and Status Controller

This block collects interrupt events from a network-MAC-style peripheral into a per-source status register. It holds a per-source mask register and drives one registered interrupt request line. Software works the block through a simple register bus: a write strobe and a read strobe, an 8-bit byte offset, and 32-bit data. Reads are combinational from the offset while the read strobe is high.

The mask cannot be written directly. Software clears mask bits through a write-one-to-enable register and sets them through a write-one-to-disable register. The mask itself is read-only; a mask bit of 1 means the source is disabled. A write to the mask's own offset has another use. It loads the written word straight into the status bits, whatever the mask holds, so software can raise or withdraw interrupts for testing.

Status bits are sticky. Bits that the clear-on-read parameter selects are cleared when the status register is read; by default that is bit 27, the receive low-power-idle change. A hardware event that arrives in the same cycle as that read still leaves its bit set.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask reads 0x07FFFFFF, the status reads 0 and `irq_o` is 0.
- R2: A write to offset 0x028 clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to offset 0x02C sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x030 loads the written value into the implemented status bits, both ones and zeros, whatever the mask holds. The mask does not change.
- R5: `irq_o` equals the OR over all sources of (status AND NOT mask), as those registers stood one clock earlier.
- R6: A read of offset 0x024 returns the status and then clears the clear-on-read bits (default: bit 27 only). All other status bits keep their value.
- R7: An event on a clear-on-read source in the same cycle as a status read leaves that status bit set.
- R8: Bits at or above `NUM_SRC` (default 28, so bits 31..28) read 0 in the mask and in the status, and writes to any register do not touch them.
- R9: Offsets 0x028 and 0x02C read 0, and so does every offset that holds no register.
- R10: A 1 on `event_i[b]` sets status bit b. The bit stays set until a test write or a clear-on-read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when `rd_en` is low |
| event_i | input | NUM_SRC | Per-source event pulses from the peripheral |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event that collides with a clear-on-read access. The event must land in the same clock edge as the status read, and the status bit must already be set by an earlier event. The bench first injects bit 27 through the test path. It then holds the read strobe, the status offset and `event_i[27]` together for one cycle, and reads the status again to confirm the bit survived. Every source bit, including the reserved ones, is also swept one at a time through enable, disable and test-path injection. The expected mask, status and request are computed arithmetically in the bench.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h24;
   localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h28;
   localparam logic [ADDR_W-1:0] OFS_DISABLE = 8'h2C;
   localparam logic [ADDR_W-1:0] OFS_MASK = 8'h30;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_ENABLE,
      SEL_DISABLE,
      SEL_MASK
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
      case (a)
         OFS_STATUS:  return SEL_STATUS;
         OFS_ENABLE:  return SEL_ENABLE;
         OFS_DISABLE: return SEL_DISABLE;
         OFS_MASK:    return SEL_MASK;
         default:     return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int          NUM_SRC = 28,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] RST_VAL = 32'h07FF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_we,
   input  logic              dis_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < NUM_SRC) begin : g_impl
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q <= RST_VAL[b];
            else if (dis_we && wdata[b]) q <= 1'b1;
            else if (en_we && wdata[b])  q <= 1'b0;
         end
         assign mask_o[b] = q;
      end else begin : g_rsvd
         logic unused_wbit;
         assign unused_wbit = wdata[b];
         assign mask_o[b]   = 1'b0;
      end
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int          NUM_SRC  = 28,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] COR_BITS = 32'h0800_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               force_we,
   input  logic               rd_clr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] event_i,
   output logic [DATA_W-1:0]  status_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < NUM_SRC) begin : g_impl
         logic q, held;
         if (COR_BITS[b]) begin : g_cor
            assign held = rd_clr ? 1'b0 : q;
         end else begin : g_sticky
            assign held = q;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (force_we ? wdata[b] : held) | event_i[b];
         end
         assign status_o[b] = q;
      end else begin : g_rsvd
         logic unused_wbit;
         assign unused_wbit = wdata[b];
         assign status_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_req_reduce.sv
module irq_req_reduce #(
   parameter int NUM_SRC    = 28,
   parameter bit REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic               irq_o
);
   logic pend;
   assign pend = |(status_i & ~mask_i);

   if (REGISTERED) begin : g_reg
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= pend;
      end
      assign irq_o = q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o      = pend;
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int          NUM_SRC    = 28,
   parameter logic [31:0] MASK_RST   = 32'h07FF_FFFF,
   parameter logic [31:0] COR_BITS   = 32'h0800_0000,
   parameter bit          REG_IRQ    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [7:0]         addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic [NUM_SRC-1:0] event_i,
   output logic               irq_o
);
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_mask_ctrl: NUM_SRC out of range");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;

   assign sel = decode_ofs(addr);

   irq_mask_bank #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RST_VAL(MASK_RST)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (wr_en && sel == SEL_ENABLE),
      .dis_we (wr_en && sel == SEL_DISABLE),
      .wdata  (wdata),
      .mask_o (mask_q)
   );

   irq_status_bank #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .COR_BITS(COR_BITS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_we (wr_en && sel == SEL_MASK),
      .rd_clr   (rd_en && sel == SEL_STATUS),
      .wdata    (wdata),
      .event_i  (event_i),
      .status_o (status_q)
   );

   irq_req_reduce #(
      .NUM_SRC(NUM_SRC), .REGISTERED(REG_IRQ)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q[NUM_SRC-1:0]),
      .mask_i   (mask_q[NUM_SRC-1:0]),
      .irq_o    (irq_o)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_STATUS: rdata = status_q;
            SEL_MASK:   rdata = mask_q;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
   parameter int NUM_SRC = 28
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [7:0]         addr,
   input logic [31:0]        wdata,
   input logic [31:0]        rdata,
   input logic [NUM_SRC-1:0] event_i,
   input logic [31:0]        st_q,
   input logic [31:0]        mk_q,
   input logic               irq_o
);
   localparam logic [31:0] IMPL = 32'hFFFF_FFFF >> (32 - NUM_SRC);

   assert_enable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h28) |=> ((mk_q & $past(wdata & IMPL)) == 32'h0));

   assert_disable_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h2C) |=> ((mk_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

   assert_test_write_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h30) |=> (mk_q == $past(mk_q)));

   assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|(st_q & ~mk_q & IMPL))));

   assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|event_i) |=> ((st_q & $past({{(32-NUM_SRC){1'b0}}, event_i})) ==
                      $past({{(32-NUM_SRC){1'b0}}, event_i})));

   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdata & ~IMPL) == 32'h0));

   assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == 8'h28 || addr == 8'h2C)) |-> (rdata == 32'h0));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .event_i (event_i),
   .st_q    (status_q),
   .mk_q    (mask_q),
   .irq_o   (irq_o)
);

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;
   localparam int          NSRC = 28;
   localparam logic [31:0] IMPL = 32'h0FFF_FFFF;
   localparam logic [31:0] COR  = 32'h0800_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = 8'h0;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic [NSRC-1:0] event_i = '0;
   logic        irq_o;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_mask, exp_st, got;

   always #10 clk = ~clk;

   irq_mask_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .event_i(event_i), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #2 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
      if (a == 8'h24) exp_st = exp_st & ~COR;
   endtask

   task automatic pulse(input logic [NSRC-1:0] ev);
      @(negedge clk);
      event_i = ev;
      @(posedge clk); #1;
      event_i = '0;
      exp_st = exp_st | {4'h0, ev};
   endtask

   task automatic irq_check(input string req);
      @(posedge clk); #1;
      check(req, {31'h0, irq_o}, {31'h0, |(exp_st & ~exp_mask & IMPL)});
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      exp_mask = 32'h07FF_FFFF;
      exp_st   = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {31'h0, irq_o}, 32'h0);
      rd(8'h30, got); check("R1 mask", got, 32'h07FF_FFFF);
      rd(8'h24, got); check("R1 status", got, 32'h0);

      // R2 / R3 / R8 single-bit enable and disable sweep
      for (int i = 0; i < 32; i++) begin
         wr(8'h28, 32'h1 << i);
         exp_mask = exp_mask & ~(32'h1 << i);
         rd(8'h30, got); check("R2 enable bit", got, exp_mask);
         wr(8'h2C, 32'h1 << i);
         exp_mask = (exp_mask | (32'h1 << i)) & IMPL;
         rd(8'h30, got); check("R3 disable bit / R8 reserved", got, exp_mask);
      end
      wr(8'h28, 32'hFFFF_FFFF); exp_mask = 32'h0;
      rd(8'h30, got); check("R2 enable all", got, 32'h0);
      wr(8'h2C, 32'hA5A5_A5A5); exp_mask = 32'hA5A5_A5A5 & IMPL;
      rd(8'h30, got); check("R3 pattern", got, exp_mask);
      wr(8'h28, 32'h0000_0000);
      rd(8'h30, got); check("R2 zero write no effect", got, exp_mask);

      // R9 write-only and unmapped offsets
      rd(8'h28, got); check("R9 enable reads 0", got, 32'h0);
      rd(8'h2C, got); check("R9 disable reads 0", got, 32'h0);
      rd(8'h34, got); check("R9 unmapped reads 0", got, 32'h0);

      // R4 / R5 / R8 test-path sweep
      for (int i = 0; i < 32; i++) begin
         wr(8'h2C, 32'hFFFF_FFFF); exp_mask = IMPL;
         wr(8'h30, 32'h1 << i); exp_st = (32'h1 << i) & IMPL;
         irq_check("R5 masked no irq");
         rd(8'h30, got); check("R4 mask unchanged", got, IMPL);
         rd(8'h24, got); check("R4 injected status", got, (32'h1 << i) & IMPL);
         wr(8'h28, 32'h1 << i); exp_mask = IMPL & ~(32'h1 << i);
         irq_check("R5 unmasked irq");
         wr(8'h30, 32'h0); exp_st = 32'h0;
         irq_check("R4 clear drops irq");
      end

      // R10 events set sticky bits
      wr(8'h2C, 32'hFFFF_FFFF); exp_mask = IMPL;
      for (int i = 0; i < NSRC; i++) begin
         pulse(NSRC'(1) << i);
         rd(8'h24, got); check("R10 event sets", got, ((exp_st | COR) & (32'h1 << i)) | (exp_st & ~COR));
      end
      rd(8'h24, got); check("R10 sticky", got, exp_st);
      wr(8'h30, 32'h0); exp_st = 32'h0;

      // R6 clear-on-read only touches bit 27
      wr(8'h30, 32'h0800_0008); exp_st = 32'h0800_0008;
      rd(8'h24, got); check("R6 first read", got, 32'h0800_0008);
      rd(8'h24, got); check("R6 second read", got, 32'h0000_0008);

      // R7 event on bit 27 collides with status read
      wr(8'h30, 32'h0800_0000); exp_st = 32'h0800_0000;
      @(negedge clk);
      rd_en = 1'b1; addr = 8'h24; event_i = NSRC'(1) << 27;
      #2 got = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0; event_i = '0;
      check("R7 read during event", got, 32'h0800_0000);
      rd(8'h24, got); check("R7 bit survives", got, 32'h0800_0000);
      rd(8'h24, got); check("R6 cleared after", got, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule